// File: doc/BRIEF.md
# Synchronous Serial Port with Eighth-Edge Wait

This block is an 8-bit clocked serial port built around a single presettable shift register. Each transfer moves one byte out and one byte in at the same time. The port has three pins: a shift clock, which the block either drives or receives, a data output and a data input. Software writes the outgoing byte into a data buffer, and the received byte comes back through a separate buffer output. The shift register itself is never accessed directly.

A mode register selects where the shift clock comes from. In internal mode the block derives the shift clock from the system clock at one of four division ratios. In external mode it follows an off-chip clock, after passing that clock through a synchronizer. An edge counter counts shift-clock rising edges and raises a flag on the eighth.

When waiting is enabled, that flag freezes the port until software writes a release command to the mode register. While frozen, the internal clock is held high and external clock edges are ignored. When waiting is disabled, the port drops back to idle after the eighth edge.

Top module: `sio_wait_port`

## Requirements
- R1: After a synchronous reset the outputs are: `sck_o`=1, `so_o`=1, `busy`=0, `waiting`=0, `sf8`=0, `err`=0 and `rx_data`=0.
- R2: Internal clock mode is mode bit 0 = 0. In this mode `sck_oe`=1. A data write starts a transfer of 8 shift-clock periods on `sck_o`. Each period lasts 2^(d+1) system clocks, where d is mode bits [2:1]. Each period is a low half followed by a high half. `sck_o` rests high before and after the transfer.
- R3: Data leaves most significant bit first on `so_o`. Bit 7 appears as soon as the buffer is written. Each later bit appears after a falling shift-clock edge. `so_o` holds bit 0 once the transfer ends.
- R4: `si_i` is sampled on each rising shift-clock edge. The first sample lands in bit 7. `rx_data` takes the whole received byte at the eighth rising edge and changes at no other time.
- R5: External clock mode is mode bit 0 = 1. In this mode `sck_oe`=0, and synchronized edges of `sck_i` drive both shifting and sampling.
- R6: `sf8` rises at the eighth rising edge. If mode bit 3 is 1, the port then enters wait: `waiting`=1 and `busy`=0.
- R7: During wait, `sck_o` stays high, and edges on `sck_i` change neither `rx_data` nor `so_o`.
- R8: A mode write with bit 4 = 1 during wait clears `waiting` and `sf8`. After that, a data write starts a new transfer.
- R9: If mode bit 3 is 0, the port returns to idle at the eighth rising edge with `sf8`=1. A data write then starts the next transfer without any release.
- R10: A data write while `busy` or `waiting` is ignored: the transfer in flight is unchanged. Such a write sets the sticky `err`, which only a mode write with bit 5 = 1 clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 6 | Mode word: [0] external clock, [2:1] divider, [3] wait enable, [4] release, [5] error clear |
| dat_we | input | 1 | Data buffer write strobe |
| dat_wdata | input | DATA_W | Byte to transmit |
| rx_data | output | DATA_W | Last received byte |
| sck_i | input | 1 | Shift clock from the pin |
| sck_o | output | 1 | Shift clock driven by the block |
| sck_oe | output | 1 | Shift clock output enable |
| so_o | output | 1 | Serial data out |
| si_i | input | 1 | Serial data in |
| busy | output | 1 | Transfer in progress |
| waiting | output | 1 | Held in wait after eighth edge |
| sf8 | output | 1 | Eighth rising edge reached |
| err | output | 1 | Sticky rejected-write flag |

## Verification
The bench drives internal-mode transfers at all four divider settings. It compares the shift clock, the data output and the status bits on every clock against a timing model. A divider that is off by one, or a clock that rests low, would show up as a shifted edge. A shifter that sends the least significant bit first, or lets the first bit wait for a falling edge, would give wrong `so_o` values. The bench writes to the data buffer in the middle of a transfer and again while the port is in wait; a design that accepts either write would corrupt the received byte or start shifting again. It also toggles the external clock while the port is in wait, two transfers run back to back without a release in between, and the bench checks that a release clears the edge count.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int SIO_DIV_W     = 2;
    localparam int MODE_EXT_BIT  = 0;
    localparam int MODE_DIV_LSB  = 1;
    localparam int MODE_WAIT_BIT = MODE_DIV_LSB + SIO_DIV_W;
    localparam int MODE_REL_BIT  = MODE_WAIT_BIT + 1;
    localparam int MODE_CLR_BIT  = MODE_REL_BIT + 1;
    localparam int SIO_CFG_W     = MODE_CLR_BIT + 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_WAIT  = 2'd2
    } sio_state_e;

    typedef struct packed {
        logic                 ext_clk;
        logic [SIO_DIV_W-1:0] div_sel;
        logic                 wait_en;
    } sio_mode_t;

    typedef struct packed {
        logic release_req;
        logic err_clear;
    } sio_cmd_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic sdi;
    } sio_edge_t;

    function automatic sio_mode_t mode_fields(input logic [SIO_CFG_W-1:0] w);
        sio_mode_t m;
        m.ext_clk = w[MODE_EXT_BIT];
        m.div_sel = w[MODE_DIV_LSB +: SIO_DIV_W];
        m.wait_en = w[MODE_WAIT_BIT];
        return m;
    endfunction

    function automatic sio_cmd_t cmd_fields(input logic [SIO_CFG_W-1:0] w);
        sio_cmd_t c;
        c.release_req = w[MODE_REL_BIT];
        c.err_clear   = w[MODE_CLR_BIT];
        return c;
    endfunction

endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen
    import sio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic [SIO_DIV_W-1:0] div_sel,
    input  logic                 si_raw,
    output logic                 sck,
    output sio_edge_t            edg_o
);
    localparam int HC_W = 1 << SIO_DIV_W;

    logic [HC_W-1:0] hc;
    logic [HC_W-1:0] lim;
    logic            sck_q;
    logic            tick;

    // half period is 2^div_sel system clocks
    assign lim  = (HC_W)'((32'd1 << div_sel) - 32'd1);
    assign tick = run && (hc == lim);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hc    <= '0;
            sck_q <= 1'b1;
        end else if (tick) begin
            hc    <= '0;
            sck_q <= ~sck_q;
        end else begin
            hc    <= hc + 1'b1;
        end
    end

    assign sck       = sck_q;
    assign edg_o.rise = tick && !sck_q;
    assign edg_o.fall = tick &&  sck_q;
    assign edg_o.sdi  = si_raw;

    assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
        !run |=> sck_q);

    assert_rise_level_R2: assert property (@(posedge clk) disable iff (rst)
        edg_o.rise |=> sck_q);

endmodule

// File: rtl/sio_pin_sync.sv
module sio_pin_sync
    import sio_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sck_pin,
    input  logic      sdi_pin,
    output sio_edge_t edg_o
);
    logic [STAGES-1:0] sck_sh;
    logic [STAGES-1:0] sdi_sh;
    logic              sck_prev;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    sck_sh[g] <= 1'b1;
                    sdi_sh[g] <= 1'b0;
                end else if (g == 0) begin
                    sck_sh[g] <= sck_pin;
                    sdi_sh[g] <= sdi_pin;
                end else begin
                    sck_sh[g] <= sck_sh[(g == 0) ? 0 : g-1];
                    sdi_sh[g] <= sdi_sh[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sck_prev <= 1'b1;
        else     sck_prev <= sck_sh[STAGES-1];
    end

    assign edg_o.rise = sck_sh[STAGES-1] && !sck_prev;
    assign edg_o.fall = !sck_sh[STAGES-1] && sck_prev;
    assign edg_o.sdi  = sdi_sh[STAGES-1];

    assert_rise_needs_low_R5: assert property (@(posedge clk) disable iff (rst)
        edg_o.rise |=> !edg_o.rise);

endmodule

// File: rtl/sio_shifter.sv
module sio_shifter
    import sio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              shift_en,
    input  sio_edge_t         edg,
    input  logic              done,
    output logic              so,
    output logic [DATA_W-1:0] rx_data
);
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] shreg_nx;
    logic              so_q;
    logic [DATA_W-1:0] rx_q;

    assign shreg_nx = {shreg[DATA_W-2:0], edg.sdi};

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            so_q  <= 1'b1;
            rx_q  <= '0;
        end else if (load) begin
            shreg <= ld_data;
            so_q  <= ld_data[DATA_W-1];
        end else if (shift_en) begin
            if (edg.rise) begin
                shreg <= shreg_nx;
                if (done) rx_q <= shreg_nx;
            end
            if (edg.fall) so_q <= shreg[DATA_W-1];
        end
    end

    assign so      = so_q;
    assign rx_data = rx_q;

endmodule

// File: rtl/sio_ctrl.sv
module sio_ctrl
    import sio_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load_req,
    input  logic release_cmd,
    input  logic err_clr_cmd,
    input  logic wait_en,
    input  logic rise,
    output logic load,
    output logic done,
    output logic busy,
    output logic waiting,
    output logic sf8,
    output logic err
);
    sio_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             err_q;

    assign load    = load_req && (state == ST_IDLE);
    assign busy    = (state == ST_SHIFT);
    assign waiting = (state == ST_WAIT);
    assign done    = busy && rise && (cnt == (CNT_W)'(DATA_W-1));
    assign sf8     = (cnt == (CNT_W)'(DATA_W));
    assign err     = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (load || release_cmd) cnt <= '0;
                    if (load) state <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (rise) cnt <= cnt + 1'b1;
                    if (done) state <= wait_en ? ST_WAIT : ST_IDLE;
                end
                ST_WAIT: begin
                    if (release_cmd) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                   err_q <= 1'b0;
        else if (load_req && state != ST_IDLE)     err_q <= 1'b1;
        else if (err_clr_cmd)                      err_q <= 1'b0;
    end

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
        cnt <= (CNT_W)'(DATA_W));

    assert_wait_after_eighth_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |-> sf8);

    assert_release_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && release_cmd) |=> (state == ST_IDLE && !sf8));

    assert_err_set_R10: assert property (@(posedge clk) disable iff (rst)
        (load_req && state != ST_IDLE) |=> err_q);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (err_q && !err_clr_cmd) |=> err_q);

endmodule

// File: rtl/sio_wait_port.sv
module sio_wait_port
    import sio_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [SIO_CFG_W-1:0] cfg_wdata,
    input  logic                 dat_we,
    input  logic [DATA_W-1:0]    dat_wdata,
    output logic [DATA_W-1:0]    rx_data,
    input  logic                 sck_i,
    output logic                 sck_o,
    output logic                 sck_oe,
    output logic                 so_o,
    input  logic                 si_i,
    output logic                 busy,
    output logic                 waiting,
    output logic                 sf8,
    output logic                 err
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    sio_mode_t mode_q;
    sio_cmd_t  cmd;
    sio_edge_t int_edg, ext_edg, sel_edg;
    logic      load, done, int_run;

    always_ff @(posedge clk) begin
        if (rst)         mode_q <= '0;
        else if (cfg_we) mode_q <= mode_fields(cfg_wdata);
    end

    assign cmd     = cmd_fields(cfg_wdata);
    assign int_run = busy && !mode_q.ext_clk;
    assign sel_edg = mode_q.ext_clk ? ext_edg : int_edg;
    assign sck_oe  = !mode_q.ext_clk;

    sio_clkgen u_clkgen (
        .clk     (clk),
        .rst     (rst),
        .run     (int_run),
        .div_sel (mode_q.div_sel),
        .si_raw  (si_i),
        .sck     (sck_o),
        .edg_o   (int_edg)
    );

    sio_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .sck_pin (sck_i),
        .sdi_pin (si_i),
        .edg_o   (ext_edg)
    );

    sio_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .load_req    (dat_we),
        .release_cmd (cfg_we && cmd.release_req),
        .err_clr_cmd (cfg_we && cmd.err_clear),
        .wait_en     (mode_q.wait_en),
        .rise        (sel_edg.rise),
        .load        (load),
        .done        (done),
        .busy        (busy),
        .waiting     (waiting),
        .sf8         (sf8),
        .err         (err)
    );

    sio_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .ld_data  (dat_wdata),
        .shift_en (busy),
        .edg      (sel_edg),
        .done     (done),
        .so       (so_o),
        .rx_data  (rx_data)
    );

    assert_so_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
        (!mode_q.ext_clk && busy && $past(busy) && !$stable(so_o)) |-> $fell(sck_o));

    assert_rx_at_eighth_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_data) |-> sf8);

    assert_wait_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (waiting && $past(waiting)) |-> ($stable(rx_data) && $stable(so_o) && sck_o));

endmodule

// File: tb/sio_wait_port_bench.sv
module sio_wait_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [5:0]    cfg_wdata = '0;
    logic          dat_we = 1'b0;
    logic [DW-1:0] dat_wdata = '0;
    logic [DW-1:0] rx_data;
    logic          sck_i = 1'b1;
    logic          sck_o, sck_oe, so_o;
    logic          si_i = 1'b0;
    logic          busy, waiting, sf8, err;

    int  total = 0;
    int  bad = 0;
    bit  model_err = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_wait_port u_sio_wait_port (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .dat_we(dat_we), .dat_wdata(dat_wdata), .rx_data(rx_data),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .so_o(so_o),
        .si_i(si_i), .busy(busy), .waiting(waiting), .sf8(sf8), .err(err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cfg_write(input logic [5:0] v);
        cfg_wdata = v; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // per-clock timing model of one internally clocked transfer
    task automatic int_xfer(input logic [7:0] data, input logic [7:0] rxpat,
                            input int sel, input bit wen, input int poke);
        int half, last;
        half = 1 << sel;
        last = 16 * half;
        cfg_write({2'b00, wen, sel[1:0], 1'b0});
        dat_wdata = data; dat_we = 1'b1; si_i = rxpat[7];
        @(negedge clk);
        dat_we = 1'b0;
        chk("R2 sck_oe", sck_oe, 1);
        for (int n = 0; n <= last + 5; n++) begin
            int t, falls, j;
            logic e_sck, e_so;
            t     = (n / half > 16) ? 16 : n / half;
            falls = (t + 1) / 2;
            e_sck = (n >= last) ? 1'b1 : ((n / half) % 2 == 0);
            e_so  = (falls == 0) ? data[7] : data[8 - falls];
            chk((n >= last) ? "R7 sck_o idle" : "R2 sck_o", sck_o, e_sck);
            chk("R3 so_o", so_o, e_so);
            chk((n >= last) ? "R9 busy" : "R2 busy", busy, n < last);
            chk("R6 sf8", sf8, n >= last);
            chk("R6 waiting", waiting, (n >= last) && wen);
            chk("R10 err", err, model_err);
            if (n == poke) begin
                dat_wdata = ~data; dat_we = 1'b1;
            end else begin
                dat_we = 1'b0;
            end
            j = n / (2 * half) + 1;
            if (j <= 8) si_i = rxpat[8 - j];
            @(negedge clk);
            if (n == poke) model_err = 1'b1;
        end
        dat_we = 1'b0;
        chk("R4 rx_data", rx_data, rxpat);
    endtask

    task automatic ext_xfer(input logic [7:0] data, input logic [7:0] rxpat, input bit wen);
        cfg_write({2'b00, wen, 2'b00, 1'b1});
        sck_i = 1'b1;
        chk("R5 sck_oe", sck_oe, 0);
        dat_wdata = data; dat_we = 1'b1;
        @(negedge clk);
        dat_we = 1'b0;
        chk("R3 first bit", so_o, data[7]);
        chk("R5 busy", busy, 1);
        for (int j = 1; j <= 8; j++) begin
            sck_i = 1'b0; si_i = rxpat[8 - j];
            repeat (4) @(negedge clk);
            chk("R3 R5 so_o", so_o, data[8 - j]);
            sck_i = 1'b1;
            repeat (4) @(negedge clk);
        end
        chk("R5 rx_data", rx_data, rxpat);
        chk("R6 sf8", sf8, 1);
        chk("R6 waiting", waiting, wen);
        chk("R9 busy", busy, 0);
        chk("R3 last bit", so_o, data[0]);
        if (wen) begin
            for (int k = 0; k < 2; k++) begin
                sck_i = 1'b0; si_i = ~si_i;
                repeat (4) @(negedge clk);
                sck_i = 1'b1;
                repeat (4) @(negedge clk);
            end
            chk("R7 rx frozen", rx_data, rxpat);
            chk("R7 so frozen", so_o, data[0]);
            chk("R7 still waiting", waiting, 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 sck_o", sck_o, 1);
        chk("R1 so_o", so_o, 1);
        chk("R1 busy", busy, 0);
        chk("R1 waiting", waiting, 0);
        chk("R1 sf8", sf8, 0);
        chk("R1 err", err, 0);
        chk("R1 rx_data", rx_data, 0);

        int_xfer(8'hA5, 8'h3C, 0, 1'b0, -1);
        int_xfer(8'h5A, 8'hC3, 2, 1'b0, -1);   // R9 back to back, no release
        int_xfer(8'h81, 8'h7E, 1, 1'b1, 5);    // R10 write mid-transfer

        // R10 write while waiting is rejected
        dat_wdata = 8'hFF; dat_we = 1'b1;
        @(negedge clk);
        dat_we = 1'b0;
        chk("R10 busy after write in wait", busy, 0);
        chk("R10 still waiting", waiting, 1);
        chk("R10 err", err, 1);
        chk("R10 rx kept", rx_data, 8'h7E);

        cfg_write(6'b111010);                   // release + error clear
        model_err = 1'b0;
        chk("R8 waiting", waiting, 0);
        chk("R8 sf8", sf8, 0);
        chk("R10 err cleared", err, 0);

        int_xfer(8'h96, 8'h69, 3, 1'b1, -1);   // R8 new transfer after release
        cfg_write(6'b011110);
        chk("R8 waiting", waiting, 0);
        chk("R8 sf8", sf8, 0);

        ext_xfer(8'hC6, 8'h5B, 1'b1);
        cfg_write(6'b011001);
        chk("R8 waiting ext", waiting, 0);
        chk("R8 sf8 ext", sf8, 0);

        ext_xfer(8'h3D, 8'hE2, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule